// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single bus requests from an 8-bit processor core into external machine cycles on a bus where the low address byte and the data byte share one set of lines in time. The core presents a cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), a 16-bit address and a write byte. The sequencer then walks a fixed run of T-states. It drives the upper address byte, the shared address/data lines with their output enable, an address strobe, active-low read and write strobes, and a memory-versus-I/O select.

The first T-state places the low address byte on the shared lines and pulses the address strobe. The later T-states use the same lines for data. A built-in transparent holding stage rebuilds the full 16-bit address from the strobe, and a capture register returns the read byte to the core together with a one-clock completion pulse.

The core may only start a cycle while the sequencer is idle, which `req_ready` reports. An opcode fetch occupies four T-states and every other kind occupies three. The completion pulse follows in the clock after the last T-state, and the sequencer is idle again in that clock.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is held and in the first clock after it, `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `done`=0.
- R2: The `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. A request is taken at a rising edge where `req_valid`=1 and `req_ready`=1. Codes 5 to 7 are ignored. A request made while `req_ready`=0 is ignored and does not disturb the cycle in progress.
- R3: The clock after a request is taken is T1. An opcode fetch lasts T1 to T4, and every other kind lasts T1 to T3. `ale` is high in T1 only.
- R4: `addr_hi` shows address bits 15:8 of the taken request in every T-state of the cycle.
- R5: In T1, `ad_oe`=1 and `ad_out` shows address bits 7:0.
- R6: In read kinds (0, 1, 3), `rd_n`=0 exactly in T2 and T3, `wr_n`=1 throughout, and `ad_oe`=0 from T2 to the end of the cycle. In fetch T4, `rd_n`=1.
- R7: In write kinds (2, 4), `wr_n`=0 exactly in T2 and T3, `rd_n`=1 throughout, and `ad_oe`=1 with `ad_out` equal to the write byte in T2 and T3.
- R8: `io_m`=0 during memory cycles (kinds 0, 1, 2) and `io_m`=1 during I/O cycles (kinds 3, 4).
- R9: For read kinds, `rdata` takes the value on `ad_in` at the rising edge that ends T3. It is valid while `done`=1 and holds until the next read capture.
- R10: `done` is high for exactly one clock, in the clock after the last T-state. In that clock `req_ready`=1.
- R11: The low byte of `lat_addr` follows `ad_out` while `ale`=1 and holds that value after `ale` falls. The high byte of `lat_addr` is `addr_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Value driven onto the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Value read back from the shared lines |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| lat_addr | output | 16 | Rebuilt full address |
| rdata | output | 8 | Byte captured in the last read cycle |
| done | output | 1 | One-clock completion pulse |

## Verification
The T-state counter is the only state that shapes the port pattern. A wrong count shows up in the same clock as a misplaced `ale`, strobe or output enable, and it also changes the cycle length seen from the first `ale` to `done`. A wrong held address or cycle kind shows on `addr_hi`, `io_m` or the rebuilt address within the T-state after the fault. This is checked across random cycles and across requests made while busy. A capture at the wrong edge is caught by changing `ad_in` before T2 and after T3, so `rdata` differs by the time `done` is high.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } cyc_kind_e;

    localparam logic [2:0] T_LAST_FETCH = 3'd4;
    localparam logic [2:0] T_LAST_RW    = 3'd3;

endpackage

// File: rtl/mux_bus_seq_ctrl.sv
module mux_bus_seq_ctrl
    import mux_bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              sample,
    output logic              done
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [2:0]        tcnt;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } ctl_s;

    ctl_s       ctl_q, ctl_d;
    logic [2:0] last_t;
    logic       is_rd, is_wr, data_phase;

    always_comb begin
        last_t = (ctl_q.kind == K_FETCH) ? T_LAST_FETCH : T_LAST_RW;
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (ctl_q.tcnt == 3'd0) begin
            if (req_valid && (req_kind <= 3'd4)) begin
                ctl_d.tcnt  = 3'd1;
                ctl_d.kind  = cyc_kind_e'(req_kind);
                ctl_d.addr  = req_addr;
                ctl_d.wdata = req_wdata;
            end
        end else if (ctl_q.tcnt == last_t) begin
            ctl_d.tcnt = 3'd0;
            ctl_d.done = 1'b1;
        end else begin
            ctl_d.tcnt = ctl_q.tcnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{tcnt: 3'd0, kind: K_FETCH, addr: '0, wdata: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        is_rd      = (ctl_q.kind == K_FETCH) || (ctl_q.kind == K_MRD) || (ctl_q.kind == K_IORD);
        is_wr      = (ctl_q.kind == K_MWR) || (ctl_q.kind == K_IOWR);
        data_phase = (ctl_q.tcnt == 3'd2) || (ctl_q.tcnt == 3'd3);
        ale        = (ctl_q.tcnt == 3'd1);
        rd_n       = !(is_rd && data_phase);
        wr_n       = !(is_wr && data_phase);
        ad_oe      = ale || (is_wr && data_phase);
        if (ale) begin
            ad_out = ctl_q.addr[DATA_W-1:0];
        end else if (is_wr && data_phase) begin
            ad_out = ctl_q.wdata;
        end else begin
            ad_out = '0;
        end
        addr_hi   = ctl_q.addr[ADDR_W-1:DATA_W];
        io_m      = (ctl_q.kind == K_IORD) || (ctl_q.kind == K_IOWR);
        sample    = is_rd && (ctl_q.tcnt == 3'd3);
        req_ready = (ctl_q.tcnt == 3'd0);
        done      = ctl_q.done;
    end

    // R3: address strobe never lasts more than one clock
    p_ale_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3: a fourth T-state belongs to a fetch only
    p_t4_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.tcnt == 3'd4) |-> (ctl_q.kind == K_FETCH) && rd_n && !ad_oe);

    // R4: upper address byte does not move inside a cycle
    p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.tcnt != 3'd0 && ctl_q.tcnt != last_t) |=> $stable(addr_hi));

    // R6: shared lines released while the read strobe is low
    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe && wr_n);

    // R7: shared lines driven while the write strobe is low
    p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe && rd_n);

    // R10: completion is a single-clock pulse and finds the sequencer idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready ##1 !done);

    // R2: no new cycle starts while one is running
    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !(ctl_q.tcnt == last_t)) |=> !req_ready && !ale);

    logic [HI_W-1:0] unused_hi_w;
    assign unused_hi_w = '0;
endmodule

// File: rtl/mux_bus_seq_latch.sv
module mux_bus_seq_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale,
    input  logic [DATA_W-1:0]        ad_out,
    input  logic [ADDR_W-DATA_W-1:0] addr_hi,
    input  logic                     sample,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-1:0]        lat_addr,
    output logic [DATA_W-1:0]        rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] rd;
    } hold_s;

    hold_s hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (ale) begin
            hold_d.lo = ad_out;
        end
        if (sample) begin
            hold_d.rd = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '{lo: '0, rd: '0};
        end else begin
            hold_q <= hold_d;
        end
    end

    // transparent while the strobe is high, held value afterwards
    assign lat_addr = {addr_hi, (ale ? ad_out : hold_q.lo)};
    assign rdata    = hold_q.rd;

    // R11: rebuilt low byte holds while the strobe is low
    p_lat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |-> lat_addr[DATA_W-1:0] == $past(lat_addr[DATA_W-1:0]));

    // R9: read byte is the bus value at the capture edge
    p_rdata_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sample) |-> rdata == $past(ad_in));

    // R9: read byte holds between captures
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample) |-> $stable(rdata));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic [ADDR_W-1:0]        lat_addr,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);
    logic sample;

    mux_bus_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_m      (io_m),
        .sample    (sample),
        .done      (done)
    );

    mux_bus_seq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .ad_out   (ad_out),
        .addr_hi  (addr_hi),
        .sample   (sample),
        .ad_in    (ad_in),
        .lat_addr (lat_addr),
        .rdata    (rdata)
    );
endmodule

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  ad_in = 8'h0;
    logic        req_ready, ad_oe, ale, rd_n, wr_n, io_m, done;
    logic [7:0]  addr_hi, ad_out, rdata;
    logic [15:0] lat_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mux_bus_seq i_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
        .lat_addr(lat_addr), .rdata(rdata), .done(done)
    );

    function automatic int exp_len(input logic [2:0] k);
        return (k == 3'd0) ? 4 : 3;
    endfunction
    function automatic bit exp_rd(input logic [2:0] k);
        return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    endfunction
    function automatic bit exp_io(input logic [2:0] k);
        return (k == 3'd3) || (k == 3'd4);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rb,
                             input bit poke);
        int  len;
        bit  rd;
        logic [7:0] keep_rd;
        len = exp_len(k);
        rd  = exp_rd(k);
        keep_rd = rdata;
        @(negedge clk);
        check("R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        ad_in = ~rb;
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            if (t == 1) req_valid = 1'b0;
            check("R3", "ale", ale, (t == 1));
            check("R4", "addr_hi", addr_hi, a[15:8]);
            check("R8", "io_m", io_m, exp_io(k));
            check("R11", "lat_addr", lat_addr, a);
            check("R2", "ready busy", req_ready, 0);
            check("R10", "done busy", done, 0);
            check("R6", "rd_n", rd_n, !(rd && (t == 2 || t == 3)));
            check("R7", "wr_n", wr_n, !(!rd && (t == 2 || t == 3)));
            if (t == 1) begin
                check("R5", "ad_oe T1", ad_oe, 1);
                check("R5", "ad_out T1", ad_out, a[7:0]);
            end else if (rd) begin
                check("R6", "ad_oe read", ad_oe, 0);
            end else begin
                check("R7", "ad_oe write", ad_oe, 1);
                check("R7", "ad_out write", ad_out, wd);
            end
            if (t == 2) begin
                ad_in = rb;
                if (poke) begin
                    req_valid = 1'b1; req_kind = 3'd2; req_addr = ~a; req_wdata = ~wd;
                end
            end
            if (t == 3) begin
                req_valid = 1'b0;
            end
            if (t == 4) ad_in = ~rb;
        end
        @(negedge clk);
        check("R10", "done after last T", done, 1);
        check("R10", "ready with done", req_ready, 1);
        check("R3", "ale after cycle", ale, 0);
        check("R9", "rdata", rdata, rd ? rb : keep_rd);
        ad_in = ~rb;
        @(negedge clk);
        check("R10", "done pulse width", done, 0);
        check("R9", "rdata hold", rdata, rd ? rb : keep_rd);
        check("R11", "lat hold idle", lat_addr, a);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] last_a;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check("R1", "ready reset", req_ready, 1);
        check("R1", "ale reset", ale, 0);
        check("R1", "rd_n reset", rd_n, 1);
        check("R1", "wr_n reset", wr_n, 1);
        check("R1", "ad_oe reset", ad_oe, 0);
        check("R1", "done reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", req_ready, 1);
        check("R1", "ale after reset", ale, 0);

        // directed corners
        run_cycle(3'd0, 16'h0000, 8'h00, 8'hA5, 1'b0);
        run_cycle(3'd1, 16'hFFFF, 8'h00, 8'h5A, 1'b0);
        run_cycle(3'd2, 16'h12F0, 8'hC3, 8'h00, 1'b0);
        run_cycle(3'd3, 16'h4242, 8'h00, 8'hFF, 1'b0);
        run_cycle(3'd4, 16'h8001, 8'h7E, 8'h00, 1'b0);
        run_cycle(3'd0, 16'hBEEF, 8'h00, 8'h3C, 1'b1);
        last_a = 16'h8001;

        // ignored kind codes (R2)
        for (int c = 5; c <= 7; c++) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = c[2:0]; req_addr = 16'h9999;
            @(negedge clk);
            req_valid = 1'b0;
            check("R2", "ale on bad kind", ale, 0);
            check("R2", "ready on bad kind", req_ready, 1);
            check("R2", "addr_hi on bad kind", addr_hi, 8'hBE);
        end

        // random cycles
        for (int n = 0; n < 60; n++) begin
            logic [2:0]  k;
            logic [15:0] a;
            k = 3'($urandom_range(4, 0));
            a = 16'($urandom());
            run_cycle(k, a, 8'($urandom()), 8'($urandom()), ($urandom_range(3, 0) == 0));
            last_a = a;
        end
        if (last_a == 16'h0) checks++;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule